// File: doc/BRIEF.md
# SPI Data Buffers with Error Status

This block sits between an SPI shift engine and the register interface of a serial port. It holds one word waiting to be sent and one word already received. Two error conditions are flagged: a receive overrun and a transmit collision. The transmit buffer has two write ports, one for software and one for a DMA engine. The receive buffer has a read strobe. A four-bit status word reports buffer occupancy and the two error flags. The error flags are cleared by writing ones to the status word.

A small built-in shift engine supports master and slave operation with both clock phases (clock idle low). In master mode it generates the serial clock from the system clock. It starts a transfer whenever it is idle and the transmit buffer holds a word. In slave mode it follows an external serial clock and select line. A configuration input sets what happens to a word that arrives while the receive buffer is still unread: either the new word replaces the old one, or the new word is dropped.

The engine is a four-state machine:
- `ST_IDLE` waits for work.
- `ST_ARMED` is a slave with clock phase 1 that is selected and waiting for its first clock edge.
- `ST_SHIFT` moves the bits.
- `ST_DONE` is a one-cycle hand-off of the received word.

Its transitions are:
- IDLE→SHIFT on a load.
- IDLE→ARMED on select in slave phase-1 mode.
- ARMED→SHIFT on the first rising serial clock edge.
- ARMED→IDLE when select drops.
- SHIFT→DONE on the last capture edge.
- SHIFT→IDLE when a slave is deselected mid-word.
- DONE→IDLE always.

Top module: `spi_bufstat`

## Requirements
- R1: After reset, `status` reads 4'b0010. Bit 0 is receive-buffer full, bit 1 is transmit-buffer empty, bit 2 is receive overflow and bit 3 is transmit collision.
- R2: In master mode, with `ser_in` tied to `ser_out`, every word written to the transmit buffer is shifted out MSB first and received back unchanged, for both values of `cpha`.
- R3: A completed transfer places the received word on `rx_data` and sets status bit 0. A pulse on `rx_rd` clears bit 0. If a read and a completion fall in the same cycle, bit 0 stays set and no overflow is flagged.
- R4: Status bit 2 is set when a transfer completes while status bit 0 is set and no read happens in that cycle.
- R5: On an overflow, `ovf_replace`=1 loads the new word into the receive buffer. `ovf_replace`=0 drops the new word, and `rx_data` keeps the old word.
- R6: A status write with a one in bit 2 or bit 3 clears that flag. Zeros leave the flags unchanged. Status writes never change bits 0 and 1.
- R7: When a flag is set by hardware and cleared by a status write in the same cycle, the flag ends up set.
- R8: A transmit-buffer write from either port that lands in the same cycle as the shift-register load sets status bit 3. The shift register takes the buffer contents from before that write. The buffer keeps the new word and stays full.
- R9: Status bit 3 is never set while `is_master`=0 and `cpha`=0.
- R10: Status bit 1 clears on a transmit-buffer write and sets when the shift register loads without a write in the same cycle. If both write ports strobe in the same cycle, the software word wins.
- R11: As a slave, the shift register loads when select falls (`cpha`=0) or on the first rising `sclk_in` edge (`cpha`=1). Data is captured on rising edges (`cpha`=0) or on falling edges (`cpha`=1), and `ser_out` presents the word MSB first.
- R12: In master mode, the engine loads and starts a transfer in the first cycle it is idle with a full transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cpha | input | 1 | Clock phase: 0 captures on rising edges, 1 captures on falling edges |
| ovf_replace | input | 1 | Overflow policy: 1 overwrites the receive buffer, 0 keeps the old word |
| tx_wr | input | 1 | Software write strobe for the transmit buffer |
| tx_wdata | input | WORD_W | Software write data |
| dma_wr | input | 1 | DMA write strobe for the transmit buffer |
| dma_wdata | input | WORD_W | DMA write data |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | WORD_W | Receive buffer contents |
| stat_wr | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata | input | 4 | Status write data |
| status | output | 4 | {collision, overflow, tx empty, rx full} |
| sclk_in | input | 1 | Serial clock in slave mode |
| ss_n_in | input | 1 | Active-low select in slave mode |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock generated in master mode |

## Verification
The bench aims at the cycle where the buffer is written and the shift register loads, doing so in master mode, in slave phase-1 mode and in slave phase-0 mode. A design that loaded the new word, or that checked the mode wrongly, would either send the wrong data back or raise a collision that must not appear. Overflow is provoked under both policies. A wrong policy leaves the wrong word in `rx_data`. The bench then writes zeros, ones to the occupancy bits, and a clear that coincides with a hardware set. Each of these exposes a flag that clears when it should stick, or sticks when it should clear. Simultaneous strobes on both write ports show whether the software word takes priority.

// File: rtl/spi_bufstat_pkg.sv
package spi_bufstat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    localparam int STAT_W    = 4;
    localparam int STAT_RXF  = 0;
    localparam int STAT_TXE  = 1;
    localparam int STAT_ROVF = 2;
    localparam int STAT_TCOL = 3;

endpackage

// File: rtl/spi_bufstat_txbuf.sv
module spi_bufstat_txbuf #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_data,
    input  logic              dma_wr,
    input  logic [WORD_W-1:0] dma_data,
    input  logic              load,
    output logic [WORD_W-1:0] buf_q,
    output logic              full_q,
    output logic              wr_any
);

    assign wr_any = sw_wr | dma_wr;

    // Software port has priority when both strobe together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (sw_wr) begin
                buf_q <= sw_data;
            end else if (dma_wr) begin
                buf_q <= dma_data;
            end
            // A write always leaves the buffer full, even when a load happens
            // in the same cycle: the loaded word is the previous contents.
            if (wr_any) begin
                full_q <= 1'b1;
            end else if (load) begin
                full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_bufstat_rxbuf.sv
module spi_bufstat_rxbuf #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              rd,
    input  logic              replace,
    output logic [WORD_W-1:0] data_q,
    output logic              full_q,
    output logic              ovf_evt
);

    // A read in the completion cycle counts as read-then-fill.
    assign ovf_evt = done & full_q & ~rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (done) begin
                if (!full_q || rd || replace) begin
                    data_q <= word;
                end
                full_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_bufstat_flags.sv
module spi_bufstat_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic cpha,
    input  logic ovf_evt,
    input  logic load,
    input  logic tx_wr_any,
    input  logic clr_wr,
    input  logic clr_ovf,
    input  logic clr_col,
    output logic ovf_q,
    output logic col_q
);

    logic col_evt;
    logic col_visible;

    // A slave with clock phase 0 loads on the select edge, which the port
    // cannot separate from a late write, so no collision is reported there.
    assign col_visible = is_master | cpha;
    assign col_evt     = load & tx_wr_any & col_visible;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            col_q <= 1'b0;
        end else begin
            ovf_q <= ovf_evt | (ovf_q & ~(clr_wr & clr_ovf));
            col_q <= col_evt | (col_q & ~(clr_wr & clr_col));
        end
    end

endmodule

// File: rtl/spi_bufstat_engine.sv
module spi_bufstat_engine
    import spi_bufstat_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              cpha,
    input  logic              tx_full,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              sclk_out,
    output logic              load,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    eng_state_t state_q, state_d;

    logic [WORD_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  cap_cnt_q;
    logic [DIV_W-1:0]  div_q;
    logic              sclk_q;
    logic              skip_q;
    logic              sclk_in_q;
    logic              ss_n_q;

    logic sel, ss_fall, rise_s, fall_s, tick;
    logic edge_rise, edge_fall, capture, launch, last_cap;

    assign sel     = ~ss_n_in;
    assign ss_fall = ss_n_q & ~ss_n_in;
    assign rise_s  = sclk_in & ~sclk_in_q;
    assign fall_s  = ~sclk_in & sclk_in_q;
    assign tick    = is_master && (state_q == ST_SHIFT) &&
                     (div_q == DIV_W'(HALF_DIV - 1));

    assign edge_rise = is_master ? (tick & ~sclk_q) : rise_s;
    assign edge_fall = is_master ? (tick & sclk_q)  : fall_s;
    assign capture   = (state_q == ST_SHIFT) & (cpha ? edge_fall : edge_rise);
    assign launch    = (state_q == ST_SHIFT) & (cpha ? edge_rise : edge_fall);
    assign last_cap  = capture && (cap_cnt_q == CNT_W'(WORD_W - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_master) begin
                    if (tx_full) state_d = ST_SHIFT;
                end else if (!cpha) begin
                    if (ss_fall) state_d = ST_SHIFT;
                end else if (sel) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (is_master || !sel) begin
                    state_d = ST_IDLE;
                end else if (rise_s) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!is_master && !sel) begin
                    state_d = ST_IDLE;
                end else if (last_cap) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        load = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = is_master ? tx_full : (~cpha & ss_fall);
            ST_ARMED: load = ~is_master & sel & rise_s;
            ST_SHIFT: load = 1'b0;
            ST_DONE:  done = 1'b1;
        endcase
    end

    // Shift datapath and clock generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            cap_cnt_q <= '0;
            div_q     <= '0;
            sclk_q    <= 1'b0;
            skip_q    <= 1'b0;
            sclk_in_q <= 1'b0;
            ss_n_q    <= 1'b1;
        end else begin
            sclk_in_q <= sclk_in;
            ss_n_q    <= ss_n_in;
            if (load) begin
                tx_sh_q   <= tx_word;
                rx_sh_q   <= '0;
                cap_cnt_q <= '0;
                div_q     <= '0;
                sclk_q    <= 1'b0;
                // Master phase 1 still has its first launch edge ahead;
                // a phase-1 slave consumed it as the load edge.
                skip_q    <= is_master & cpha;
            end else if (state_q == ST_SHIFT) begin
                if (is_master) begin
                    div_q <= tick ? '0 : div_q + DIV_W'(1);
                    if (tick) sclk_q <= ~sclk_q;
                end
                if (capture) begin
                    rx_sh_q   <= {rx_sh_q[WORD_W-2:0], ser_in};
                    cap_cnt_q <= cap_cnt_q + CNT_W'(1);
                end
                if (launch) begin
                    if (skip_q) begin
                        skip_q <= 1'b0;
                    end else begin
                        tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
                    end
                end
                if (state_d != ST_SHIFT) begin
                    sclk_q <= 1'b0;
                    div_q  <= '0;
                end
            end
        end
    end

    assign ser_out  = tx_sh_q[WORD_W-1];
    assign sclk_out = sclk_q;
    assign rx_word  = rx_sh_q;

endmodule

// File: rtl/spi_bufstat.sv
module spi_bufstat
    import spi_bufstat_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              cpha,
    input  logic              ovf_replace,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              dma_wr,
    input  logic [WORD_W-1:0] dma_wdata,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] status,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              sclk_out
);

    logic [WORD_W-1:0] tx_buf;
    logic              tx_full;
    logic              tx_wr_any;
    logic              eng_load;
    logic              eng_done;
    logic [WORD_W-1:0] eng_word;
    logic              rx_full;
    logic              ovf_evt;
    logic              ovf_flag;
    logic              col_flag;
    logic              unused_wbits;

    // Occupancy bits are read-only; their write positions carry no meaning.
    assign unused_wbits = ^{stat_wdata[STAT_TXE], stat_wdata[STAT_RXF]};

    spi_bufstat_txbuf #(.WORD_W(WORD_W)) u_txbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (tx_wr),
        .sw_data  (tx_wdata),
        .dma_wr   (dma_wr),
        .dma_data (dma_wdata),
        .load     (eng_load),
        .buf_q    (tx_buf),
        .full_q   (tx_full),
        .wr_any   (tx_wr_any)
    );

    spi_bufstat_engine #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .cpha      (cpha),
        .tx_full   (tx_full),
        .tx_word   (tx_buf),
        .sclk_in   (sclk_in),
        .ss_n_in   (ss_n_in),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .sclk_out  (sclk_out),
        .load      (eng_load),
        .done      (eng_done),
        .rx_word   (eng_word)
    );

    spi_bufstat_rxbuf #(.WORD_W(WORD_W)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (eng_done),
        .word    (eng_word),
        .rd      (rx_rd),
        .replace (ovf_replace),
        .data_q  (rx_data),
        .full_q  (rx_full),
        .ovf_evt (ovf_evt)
    );

    spi_bufstat_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .cpha      (cpha),
        .ovf_evt   (ovf_evt),
        .load      (eng_load),
        .tx_wr_any (tx_wr_any),
        .clr_wr    (stat_wr),
        .clr_ovf   (stat_wdata[STAT_ROVF]),
        .clr_col   (stat_wdata[STAT_TCOL]),
        .ovf_q     (ovf_flag),
        .col_q     (col_flag)
    );

    always_comb begin
        status            = '0;
        status[STAT_RXF]  = rx_full;
        status[STAT_TXE]  = ~tx_full;
        status[STAT_ROVF] = ovf_flag;
        status[STAT_TCOL] = col_flag;
    end

endmodule

// File: rtl/spi_bufstat_chk.sv
module spi_bufstat_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              cpha,
    input logic              ovf_replace,
    input logic              rx_rd,
    input logic [WORD_W-1:0] rx_data,
    input logic              stat_wr,
    input logic [3:0]        stat_wdata,
    input logic [3:0]        status,
    input logic              eng_load,
    input logic              eng_done,
    input logic              tx_wr_any
);

    // R4: overflow can only rise after a cycle with a full receive buffer
    assert_ovf_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(status[0]));

    // R5: discard policy keeps the old word
    assert_discard_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && status[0] && !rx_rd && !ovf_replace) |=> $stable(rx_data));

    // R6: overflow flag persists unless a one is written to bit 2
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !(stat_wr && stat_wdata[2])) |=> status[2]);

    // R6: collision flag persists unless a one is written to bit 3
    assert_col_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !(stat_wr && stat_wdata[3])) |=> status[3]);

    // R8: master load coinciding with a buffer write raises the flag
    assert_col_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load && tx_wr_any && is_master) |=> status[3]);

    // R9: slave with clock phase 0 never raises the flag
    assert_no_col_slave_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !cpha && !status[3]) |=> !status[3]);

    // R10: a load without a write empties the transmit buffer
    assert_load_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load && !tx_wr_any) |=> status[1]);

    // R10: any write fills the transmit buffer
    assert_write_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_any |=> !status[1]);

endmodule

bind spi_bufstat spi_bufstat_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .is_master   (is_master),
    .cpha        (cpha),
    .ovf_replace (ovf_replace),
    .rx_rd       (rx_rd),
    .rx_data     (rx_data),
    .stat_wr     (stat_wr),
    .stat_wdata  (stat_wdata),
    .status      (status),
    .eng_load    (eng_load),
    .eng_done    (eng_done),
    .tx_wr_any   (tx_wr_any)
);

// File: tb/sim_spi_bufstat.sv
`timescale 1ns/1ps
module sim_spi_bufstat;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       cpha = 1'b0;
    logic       ovf_replace = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       dma_wr = 1'b0;
    logic [7:0] dma_wdata = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       stat_wr = 1'b0;
    logic [3:0] stat_wdata = '0;
    logic [3:0] status;
    logic       sclk_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi = 1'b0;
    logic       ser_in;
    logic       ser_out;
    logic       sclk_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit auto_rd = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    assign ser_in = is_master ? ser_out : mosi;

    spi_bufstat #(.WORD_W(8), .HALF_DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpha(cpha),
        .ovf_replace(ovf_replace), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .status(status),
        .sclk_in(sclk_in), .ss_n_in(ss_n_in), .ser_in(ser_in),
        .ser_out(ser_out), .sclk_out(sclk_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever a word is waiting (R2, R3)
    initial begin
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (auto_rd) begin
                rx_rd = 1'b0;
                if (rst_n && status[0]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected received word", rx_data, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(rx_data == e, "R2 received word", rx_data, e);
                    end
                    rx_rd = 1'b1;
                end
            end
        end
    end

    task automatic send_word(input logic [7:0] w, input bit via_dma, input bit expect_rx);
        @(negedge clk);
        if (via_dma) begin dma_wr = 1'b1; dma_wdata = w; end
        else begin tx_wr = 1'b1; tx_wdata = w; end
        if (expect_rx) exp_q.push_back(w);
        @(negedge clk);
        tx_wr = 1'b0; dma_wr = 1'b0;
        chk(status[1] == 1'b0, "R10 tx empty clears after write", status[1], 0);
    endtask

    task automatic drain;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && status[1] && !status[0]) break;
        end
        hold(4);
        chk(exp_q.size() == 0, "R12 all queued words transferred", exp_q.size(), 0);
        chk(status[1] == 1'b1, "R10 tx empty after load", status[1], 1);
    endtask

    task automatic stat_write(input logic [3:0] v);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
        @(negedge clk); stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic manual_read;
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        hold(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 4'b0010, "R1 reset status", status, 4'b0010);
        auto_rd = 1'b1;

        // Master, phase 0 (R2, R12)
        send_word(8'hA5, 1'b0, 1'b1); drain();
        send_word(8'h3C, 1'b0, 1'b1); drain();
        send_word(8'h81, 1'b1, 1'b1); drain();
        send_word(8'h00, 1'b0, 1'b1); drain();

        // Master, phase 1 (R2)
        cpha = 1'b1;
        send_word(8'h5A, 1'b0, 1'b1); drain();
        send_word(8'hF0, 1'b1, 1'b1); drain();
        send_word(8'h01, 1'b0, 1'b1); drain();
        chk(status[3] == 1'b0, "R8 no collision on spaced writes", status[3], 0);

        // Both ports at once: software wins (R10)
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = 8'h66; dma_wr = 1'b1; dma_wdata = 8'h99;
        exp_q.push_back(8'h66);
        @(negedge clk);
        tx_wr = 1'b0; dma_wr = 1'b0;
        drain();

        // Overflow, discard policy (R3, R4, R5, R6)
        cpha = 1'b0;
        auto_rd = 1'b0; rx_rd = 1'b0;
        ovf_replace = 1'b0;
        send_word(8'h11, 1'b0, 1'b0); hold(80);
        chk(status[0] == 1'b1, "R3 rx full after transfer", status[0], 1);
        chk(status[2] == 1'b0, "R4 no overflow on first word", status[2], 0);
        send_word(8'h22, 1'b0, 1'b0); hold(80);
        chk(status[2] == 1'b1, "R4 overflow flagged", status[2], 1);
        chk(rx_data == 8'h11, "R5 discard keeps old word", rx_data, 8'h11);
        stat_write(4'b0011);
        chk(status[0] == 1'b1, "R6 status write leaves rx full", status[0], 1);
        chk(status[2] == 1'b1, "R6 ones in bits 0,1 leave flag", status[2], 1);
        stat_write(4'b0000);
        chk(status[2] == 1'b1, "R6 zero write has no effect", status[2], 1);
        stat_write(4'b0100);
        chk(status[2] == 1'b0, "R6 write one clears overflow", status[2], 0);
        manual_read();
        chk(status[0] == 1'b0, "R3 read clears rx full", status[0], 0);

        // Overflow, replace policy (R5)
        ovf_replace = 1'b1;
        send_word(8'h33, 1'b0, 1'b0); hold(80);
        send_word(8'h44, 1'b0, 1'b0); hold(80);
        chk(status[2] == 1'b1, "R4 overflow flagged again", status[2], 1);
        chk(rx_data == 8'h44, "R5 replace stores new word", rx_data, 8'h44);
        stat_write(4'b0100);
        manual_read();
        ovf_replace = 1'b0;
        auto_rd = 1'b1;

        // Master collision: DMA write on the load cycle, with a clear in the
        // same cycle (R7, R8, R12)
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = 8'hC3;
        exp_q.push_back(8'hC3);
        @(negedge clk);
        tx_wr = 1'b0; dma_wr = 1'b1; dma_wdata = 8'h7E;
        stat_wr = 1'b1; stat_wdata = 4'b1000;
        exp_q.push_back(8'h7E);
        @(negedge clk);
        dma_wr = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
        chk(status[3] == 1'b1, "R7/R8 collision set wins over clear", status[3], 1);
        chk(status[1] == 1'b0, "R8 buffer stays full after collision", status[1], 0);
        drain();
        stat_write(4'b1000);
        chk(status[3] == 1'b0, "R6 write one clears collision", status[3], 0);

        // Slave, phase 0: write on the select edge, no flag (R9, R11, R8)
        is_master = 1'b0; cpha = 1'b0;
        hold(3);
        exp_q.push_back(8'h96);
        @(negedge clk);
        ss_n_in = 1'b0; tx_wr = 1'b1; tx_wdata = 8'h5C;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(status[3] == 1'b0, "R9 slave phase 0 never flags collision", status[3], 0);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi = 8'h96 >> i;
            hold(2);
            got[i] = ser_out;
            sclk_in = 1'b1; hold(3);
            sclk_in = 1'b0; hold(3);
        end
        ss_n_in = 1'b1;
        hold(6);
        chk(got == 8'h7E, "R11 slave phase 0 sends prior buffer word", got, 8'h7E);
        chk(exp_q.size() == 0, "R11 slave phase 0 word received", exp_q.size(), 0);
        chk(status[1] == 1'b0, "R8 new word still buffered", status[1], 0);

        // Slave, phase 1: write on the first clock edge flags (R8, R11)
        cpha = 1'b1;
        hold(3);
        exp_q.push_back(8'h3B);
        @(negedge clk);
        ss_n_in = 1'b0;
        hold(3);
        sclk_in = 1'b1; tx_wr = 1'b1; tx_wdata = 8'hE7;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(status[3] == 1'b1, "R8 slave phase 1 collision flagged", status[3], 1);
        hold(2);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi = 8'h3B >> i;
            hold(2);
            got[i] = ser_out;
            sclk_in = 1'b0; hold(3);
            if (i > 0) begin
                sclk_in = 1'b1; hold(3);
            end
        end
        ss_n_in = 1'b1;
        hold(6);
        chk(got == 8'h5C, "R11 slave phase 1 sends prior buffer word", got, 8'h5C);
        chk(exp_q.size() == 0, "R11 slave phase 1 word received", exp_q.size(), 0);
        stat_write(4'b1000);
        chk(status[3] == 1'b0, "R6 collision cleared in slave mode", status[3], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule